// File: doc/BRIEF.md
# Broadcast Multiply-Accumulate Sequencer

This block carries out one vector instruction as a fixed run of four dependent multiply-accumulate steps into a single wide accumulator. A start pulse supplies a base register index and a base memory word address. In step n the unit takes one 32-bit scalar from memory word base+n and copies it to every lane. It reads vector register base+n through a register-file read port, multiplies lane by lane, and adds the products into the same 16-lane accumulator. Each step therefore depends on the result of the one before it.

The four scalars sit in adjacent memory words. A parameter selects how they are fetched: one 128-bit read holding all four, or one 32-bit read per step. Both variants take the same number of cycles, so the choice affects only the memory traffic. The accumulator is not cleared between instructions, so successive instructions keep adding into it.

Top module: `bcast_mac4_seq`

## Requirements
- R1: After reset the accumulator is zero and `busy_o`, `done_o` and `err_o` are low.
- R2: A start whose base register index has either of its two low bits set is rejected. `err_o` is high for exactly the one cycle after the start, `busy_o` and `done_o` stay low, and the accumulator is unchanged.
- R3: An accepted start, sampled at clock edge E0, holds `busy_o` high for the five cycles after E0. In the sixth cycle `busy_o` is low and `done_o` is high for that one cycle only.
- R4: Each lane finishes an instruction as acc + s0*V[b] + s1*V[b+1] + s2*V[b+2] + s3*V[b+3], added in that order. Here sn is the memory word at base address + n and b is the base register index. Lane l of the accumulator and of a register occupies bits [32l+31:32l].
- R5: Lane arithmetic is a signed 32-bit multiply-add whose result keeps only the low 32 bits, so it wraps on overflow.
- R6: The accumulator keeps its value from one instruction to the next and is never cleared, except by reset.
- R7: A start that arrives while `busy_o` is high has no effect on the running instruction, its timing or its result, and does not begin another instruction.
- R8: With one wide read selected, exactly one read is issued, in the first cycle after E0, at the base address. Word n of the returned data sits in bits [32n+31:32n]. With per-step reads, the reads are issued in the four cycles after E0 at base, base+1, base+2 and base+3, and none follows.
- R9: Memory read data is taken in the cycle after the read is issued.
- R10: In cycle 2+n after E0 (n = 0..3), the register-file read index is base+n, and the register data on that port in that cycle is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one instruction |
| base_reg_i | input | 5 | First vector register index (must be a multiple of 4) |
| base_addr_i | input | 16 | Word address of the first scalar |
| rf_rd_idx_o | output | 5 | Register-file read index |
| rf_rd_data_i | input | 512 | Register data for `rf_rd_idx_o`, same cycle |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | 16 | Memory word address of the request |
| mem_rd_data_i | input | 128 (32 in per-step mode) | Read data, one cycle after the request |
| acc_o | output | 512 | Accumulator, 16 lanes of 32 bits |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle misaligned-index pulse |

## Verification
A wrong step counter or base latch shows up on `rf_rd_idx_o` and `mem_rd_addr_o` in the same cycle as the mistake, well before the result is visible. A wrong scalar selection, such as a wide-buffer shift error or a step taking its data from the wrong cycle, corrupts every lane of `acc_o`. That corruption is visible in the cycle `done_o` rises. Because the accumulator is never cleared, any mistake also carries into every later comparison. A controller that fails to ignore a start while busy changes the read indices within one cycle.

// File: rtl/bmac_pkg.sv
package bmac_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_ACC   = 2'd2
   } bmac_state_e;
endpackage

// File: rtl/bmac_ctrl.sv
module bmac_ctrl
   import bmac_pkg::*;
#(
   parameter int STEPS  = 4,
   parameter int RIDX_W = 5,
   parameter int AW     = 16,
   localparam int STEP_W = $clog2(STEPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [RIDX_W-1:0] base_reg_i,
   input  logic [AW-1:0]     base_addr_i,
   output logic              issue_o,
   output logic              acc_we_o,
   output logic [STEP_W-1:0] step_o,
   output logic [RIDX_W-1:0] rf_idx_o,
   output logic [AW-1:0]     addr_base_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   bmac_state_e       state_q;
   logic [STEP_W-1:0] step_q;
   logic [RIDX_W-1:0] reg_q;
   logic [AW-1:0]     addr_q;
   logic              done_q, err_q;
   logic              misaligned;

   assign misaligned = base_reg_i[STEP_W-1:0] != '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         reg_q   <= '0;
         addr_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (misaligned) begin
                     err_q <= 1'b1;
                  end else begin
                     state_q <= ST_ISSUE;
                     reg_q   <= base_reg_i;
                     addr_q  <= base_addr_i;
                     step_q  <= '0;
                  end
               end
            end
            ST_ISSUE: state_q <= ST_ACC;
            ST_ACC: begin
               step_q <= step_q + 1'b1;
               if (step_q == STEP_W'(STEPS - 1)) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign issue_o     = state_q == ST_ISSUE;
   assign acc_we_o    = state_q == ST_ACC;
   assign step_o      = step_q;
   assign rf_idx_o    = reg_q + RIDX_W'(step_q);
   assign addr_base_o = addr_q;
   assign busy_o      = state_q != ST_IDLE;
   assign done_o      = done_q;
   assign err_o       = err_q;

   // R7: a start during a running instruction leaves the latched base alone
   assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (reg_q == $past(reg_q) && addr_q == $past(addr_q)));
   // R3: completion is a single-cycle pulse and leaves the unit idle
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o ##1 !done_o));
   // R2: error is raised only from idle and never with busy
   assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && !done_o));
endmodule

// File: rtl/bmac_scalar_src.sv
module bmac_scalar_src #(
   parameter int LANE_W = 32,
   parameter int STEPS  = 4,
   parameter int AW     = 16,
   parameter bit WIDE   = 1'b1,
   localparam int STEP_W = $clog2(STEPS),
   localparam int MEM_W  = WIDE ? STEPS * LANE_W : LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic              acc_we_i,
   input  logic [STEP_W-1:0] step_i,
   input  logic [AW-1:0]     addr_base_i,
   input  logic [MEM_W-1:0]  mem_rd_data_i,
   output logic              mem_rd_en_o,
   output logic [AW-1:0]     mem_rd_addr_o,
   output logic [LANE_W-1:0] scalar_o
);
   generate
      if (WIDE) begin : g_wide
         localparam int BUF_W = (STEPS - 1) * LANE_W;
         logic [BUF_W-1:0] rest_q;

         assign mem_rd_en_o   = issue_i;
         assign mem_rd_addr_o = addr_base_i;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rest_q <= '0;
            end else if (acc_we_i) begin
               if (step_i == '0) rest_q <= mem_rd_data_i[MEM_W-1:LANE_W];
               else              rest_q <= rest_q >> LANE_W;
            end
         end

         assign scalar_o = (step_i == '0) ? mem_rd_data_i[LANE_W-1:0]
                                          : rest_q[LANE_W-1:0];

         // R8: one wide read per instruction, never back to back
         assert_single_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
            mem_rd_en_o |=> !mem_rd_en_o);
         // R8: no read is issued while steps consume the buffer
         assert_no_read_during_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
            acc_we_i |-> !mem_rd_en_o);
      end else begin : g_narrow
         assign mem_rd_en_o   = issue_i || (acc_we_i && step_i != STEP_W'(STEPS - 1));
         assign mem_rd_addr_o = addr_base_i + (issue_i ? AW'(0) : AW'(step_i) + AW'(1));
         assign scalar_o      = mem_rd_data_i;

         // R8: back-to-back per-step reads walk consecutive words
         assert_addr_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_rd_en_o && $past(mem_rd_en_o)) |-> mem_rd_addr_o == $past(mem_rd_addr_o) + AW'(1));
         // R9: each step consumes data whose read was issued the cycle before
         assert_data_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            acc_we_i |-> $past(mem_rd_en_o));
      end
   endgenerate
endmodule

// File: rtl/bmac_lane_array.sv
module bmac_lane_array #(
   parameter int LANES  = 16,
   parameter int LANE_W = 32,
   localparam int VEC_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [LANE_W-1:0] scalar_i,
   input  logic [VEC_W-1:0]  vec_i,
   output logic [VEC_W-1:0]  acc_o
);
   logic [VEC_W-1:0] acc_q;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic signed [LANE_W-1:0] a, b, cur, nxt;
         assign a   = scalar_i;
         assign b   = vec_i[i*LANE_W +: LANE_W];
         assign cur = acc_q[i*LANE_W +: LANE_W];
         assign nxt = cur + a * b;

         always_ff @(posedge clk) begin
            if (!rst_n)    acc_q[i*LANE_W +: LANE_W] <= '0;
            else if (we_i) acc_q[i*LANE_W +: LANE_W] <= nxt;
         end
      end
   endgenerate

   assign acc_o = acc_q;

   // R2, R6: the accumulator moves only on an accumulate step
   assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(acc_o));
endmodule

// File: rtl/bcast_mac4_seq.sv
module bcast_mac4_seq #(
   parameter int LANES     = 16,
   parameter int LANE_W    = 32,
   parameter int STEPS     = 4,
   parameter int REG_CNT   = 32,
   parameter int AW        = 16,
   parameter bit WIDE_FETCH = 1'b1,
   localparam int VEC_W  = LANES * LANE_W,
   localparam int RIDX_W = $clog2(REG_CNT),
   localparam int STEP_W = $clog2(STEPS),
   localparam int MEM_W  = WIDE_FETCH ? STEPS * LANE_W : LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [RIDX_W-1:0] base_reg_i,
   input  logic [AW-1:0]     base_addr_i,
   output logic [RIDX_W-1:0] rf_rd_idx_o,
   input  logic [VEC_W-1:0]  rf_rd_data_i,
   output logic              mem_rd_en_o,
   output logic [AW-1:0]     mem_rd_addr_o,
   input  logic [MEM_W-1:0]  mem_rd_data_i,
   output logic [VEC_W-1:0]  acc_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   generate
      if (STEPS < 2 || (1 << STEP_W) != STEPS) begin : g_bad_steps
         $error("STEPS must be a power of two of at least 2");
      end
      if (REG_CNT % STEPS != 0 || REG_CNT < STEPS) begin : g_bad_regs
         $error("REG_CNT must be a multiple of STEPS");
      end
      if (LANES < 1 || LANE_W < 2) begin : g_bad_lanes
         $error("LANES and LANE_W out of range");
      end
   endgenerate

   logic              issue, acc_we;
   logic [STEP_W-1:0] step;
   logic [AW-1:0]     addr_base;
   logic [LANE_W-1:0] scalar;

   bmac_ctrl #(.STEPS(STEPS), .RIDX_W(RIDX_W), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .base_reg_i(base_reg_i), .base_addr_i(base_addr_i),
      .issue_o(issue), .acc_we_o(acc_we), .step_o(step),
      .rf_idx_o(rf_rd_idx_o), .addr_base_o(addr_base),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   bmac_scalar_src #(.LANE_W(LANE_W), .STEPS(STEPS), .AW(AW), .WIDE(WIDE_FETCH)) u_src (
      .clk(clk), .rst_n(rst_n), .issue_i(issue), .acc_we_i(acc_we),
      .step_i(step), .addr_base_i(addr_base), .mem_rd_data_i(mem_rd_data_i),
      .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o), .scalar_o(scalar)
   );

   bmac_lane_array #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .we_i(acc_we), .scalar_i(scalar),
      .vec_i(rf_rd_data_i), .acc_o(acc_o)
   );

   // R10: while accumulating, the register index stays inside one aligned group
   assert_rf_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_we && $past(acc_we)) |-> rf_rd_idx_o == $past(rf_rd_idx_o) + RIDX_W'(1));
endmodule

// File: tb/tb_bcast_mac4_seq.sv
`timescale 1ns/1ps
module tb_bcast_mac4_seq;
   localparam int LANES = 16;
   localparam int LW    = 32;
   localparam int VW    = LANES * LW;
   localparam int NVEC  = 8;
   localparam int VREG  [NVEC] = '{0, 4, 28, 8, 12, 16, 20, 24};
   localparam int VADDR [NVEC] = '{0, 5, 60, 17, 33, 1, 44, 9};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          start = 1'b0;
   logic [4:0]    breg = '0;
   logic [15:0]   baddr = '0;

   logic [4:0]    w_idx, n_idx;
   logic [VW-1:0] w_rf, n_rf;
   logic          w_en, n_en;
   logic [15:0]   w_addr, n_addr;
   logic [127:0]  w_data = '0;
   logic [31:0]   n_data = '0;
   logic [VW-1:0] w_acc, n_acc;
   logic          w_busy, n_busy, w_done, n_done, w_err, n_err;

   int nchk = 0;
   int nbad = 0;
   logic [31:0] model [LANES];

   function automatic logic [31:0] mem_word(int i);
      return (32'(i) * 32'h0101_0F0F) ^ 32'hC3A5_7E11;
   endfunction

   function automatic logic [31:0] rf_word(int r, int l);
      return (32'(r) * 32'h0003_1F07 + 32'(l) * 32'h7FFF_0013) ^ (r[0] ? 32'h8000_0000 : 32'h0);
   endfunction

   function automatic logic [VW-1:0] rf_vec(logic [4:0] r);
      logic [VW-1:0] v;
      for (int l = 0; l < LANES; l++) v[l*LW +: LW] = rf_word(int'(r), l);
      return v;
   endfunction

   function automatic logic [VW-1:0] model_vec();
      logic [VW-1:0] v;
      for (int l = 0; l < LANES; l++) v[l*LW +: LW] = model[l];
      return v;
   endfunction

   assign w_rf = rf_vec(w_idx);
   assign n_rf = rf_vec(n_idx);

   always @(posedge clk) begin
      if (w_en) w_data <= {mem_word(int'(w_addr) + 3), mem_word(int'(w_addr) + 2),
                           mem_word(int'(w_addr) + 1), mem_word(int'(w_addr))};
      if (n_en) n_data <= mem_word(int'(n_addr));
   end

   bcast_mac4_seq #(.WIDE_FETCH(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_reg_i(breg), .base_addr_i(baddr),
      .rf_rd_idx_o(w_idx), .rf_rd_data_i(w_rf), .mem_rd_en_o(w_en), .mem_rd_addr_o(w_addr),
      .mem_rd_data_i(w_data), .acc_o(w_acc), .busy_o(w_busy), .done_o(w_done), .err_o(w_err)
   );

   bcast_mac4_seq #(.WIDE_FETCH(1'b0)) dut_narrow (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_reg_i(breg), .base_addr_i(baddr),
      .rf_rd_idx_o(n_idx), .rf_rd_data_i(n_rf), .mem_rd_en_o(n_en), .mem_rd_addr_o(n_addr),
      .mem_rd_data_i(n_data), .acc_o(n_acc), .busy_o(n_busy), .done_o(n_done), .err_o(n_err)
   );

   task automatic chk(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
   endtask

   // one instruction; intrude=1 pulses a second start while busy (R7)
   task automatic run_instr(int b, int a, bit intrude);
      @(negedge clk);
      start = 1'b1; breg = 5'(b); baddr = 16'(a);
      @(negedge clk);
      start = 1'b0;
      chk(w_busy && n_busy, "R3 busy c1", VW'({w_busy, n_busy}), VW'(2'b11));
      chk(w_en && w_addr == 16'(a), "R8 wide read", VW'({w_en, w_addr}), VW'({1'b1, 16'(a)}));
      chk(n_en && n_addr == 16'(a), "R8 narrow read", VW'({n_en, n_addr}), VW'({1'b1, 16'(a)}));
      for (int n = 0; n < 4; n++) begin
         @(negedge clk);
         if (intrude && n == 0) begin start = 1'b1; breg = 5'd12; baddr = 16'd3; end
         if (intrude && n == 1) start = 1'b0;
         chk(w_idx == 5'(b + n) && n_idx == 5'(b + n), "R10 index",
             VW'({w_idx, n_idx}), VW'({5'(b + n), 5'(b + n)}));
         chk(!w_en, "R8 wide no extra read", VW'(w_en), VW'(0));
         if (n < 3)
            chk(n_en && n_addr == 16'(a + n + 1), "R8 narrow walk",
                VW'({n_en, n_addr}), VW'({1'b1, 16'(a + n + 1)}));
         else
            chk(!n_en, "R8 narrow stop", VW'(n_en), VW'(0));
         chk(w_busy && n_busy && !w_done && !n_done, "R3 busy steps",
             VW'({w_busy, n_busy, w_done, n_done}), VW'(4'b1100));
      end
      for (int n = 0; n < 4; n++)
         for (int l = 0; l < LANES; l++)
            model[l] = model[l] + mem_word(a + n) * rf_word(b + n, l);
      @(negedge clk);
      start = 1'b0;
      chk(w_done && n_done && !w_busy && !n_busy, "R3 done",
          VW'({w_done, n_done, w_busy, n_busy}), VW'(4'b1100));
      chk(w_acc == model_vec(), "R4 R5 R6 R9 wide acc", w_acc, model_vec());
      chk(n_acc == model_vec(), "R4 R5 R6 R9 narrow acc", n_acc, model_vec());
      @(negedge clk);
      chk(!w_done && !n_done, "R3 done one cycle", VW'({w_done, n_done}), VW'(0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      for (int l = 0; l < LANES; l++) model[l] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(w_acc == '0 && n_acc == '0, "R1 acc zero", w_acc | n_acc, '0);
      chk(!w_busy && !w_done && !w_err && !n_busy && !n_done && !n_err, "R1 flags",
          VW'({w_busy, w_done, w_err, n_busy, n_done, n_err}), VW'(0));

      // table of base register / base address pairs; accumulator carries over (R6)
      for (int v = 0; v < NVEC; v++) run_instr(VREG[v], VADDR[v], 1'b0);

      // R7: start while busy is ignored
      run_instr(4, 20, 1'b1);
      repeat (6) begin
         @(negedge clk);
         chk(!w_busy && !n_busy && !w_done && !n_done, "R7 no second instr",
             VW'({w_busy, n_busy, w_done, n_done}), VW'(0));
      end
      chk(w_acc == model_vec() && n_acc == model_vec(), "R7 acc unchanged", w_acc, model_vec());

      // R2: misaligned base index
      @(negedge clk);
      start = 1'b1; breg = 5'd6; baddr = 16'd2;
      @(negedge clk);
      start = 1'b0;
      chk(w_err && n_err && !w_busy && !n_busy, "R2 err pulse",
          VW'({w_err, n_err, w_busy, n_busy}), VW'(4'b1100));
      @(negedge clk);
      chk(!w_err && !n_err && !w_done && !n_done && !w_busy, "R2 err one cycle",
          VW'({w_err, n_err, w_done, n_done, w_busy}), VW'(0));
      repeat (5) @(negedge clk);
      chk(w_acc == model_vec() && n_acc == model_vec(), "R2 acc unchanged", w_acc, model_vec());

      // R5: top register group with odd-index sign bits forced, then reset clears (R1)
      run_instr(28, 59, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(w_acc == '0 && n_acc == '0, "R1 acc cleared by reset", w_acc | n_acc, '0);

      summary();
      $finish;
   end
endmodule